// File: doc/BRIEF.md
# Three-Wire Link Flush Controller

This block sits on the host end of a three-wire handshake link. The guest owns the clock line, the host owns the acknowledge line, and both sides can pull the shared data line low. Each bit exchange is a four-phase handshake. The guest lowers the clock (P0 to P1). The host lowers acknowledge (P1 to P2). The guest raises the clock (P2 to P3). The host raises acknowledge (P3 to P0). After a protocol error, the link is brought back to a known idle state by a flush.

A flush-start strobe makes the host the flusher. It holds data low through a parameterised number of complete handshakes. It then waits for the next clock-low phase, drives data high and goes straight into the flush-receiving (flushee) role. A flushee-start strobe enters that role directly, which is the response when the guest is the one flushing. In the flushee role the host releases data and samples it in phase P3. A low sample costs one more full handshake. A high sample ends the flush with acknowledge high, which is link idle. Every wait for a clock level is bounded. When a wait runs out, the host sets a sticky timeout flag and returns the link to its idle levels. Both raw link inputs pass through a multi-stage synchronizer before any decision is made.

Top module: `tw_flush_ctrl`

## Requirements
- R1: While reset is active and immediately after it, ack_o is 1 and data_oe_o, busy_o, done_o and timeout_o are 0.
- R2: A flush_start_i pulse taken while idle makes the block busy one cycle later, with data_oe_o=1, data_o=0 and timeout_o cleared.
- R3: As flusher, the block lowers ack_o once the synchronized clock is seen low and raises it once the clock is seen high. It completes exactly FLUSH_CYCLES such handshakes with data driven low.
- R4: After the last flusher handshake, the block waits for the synchronized clock to go low, then drives data_o=1 with data_oe_o=1 for one cycle and enters the flushee role.
- R5: In the flushee role, data_oe_o is 0. When the synchronized clock is seen high, ack_o is raised and the synchronized data is sampled. A 0 sample leads to a wait for clock low, then ack_o=0, then a wait for clock high again. A 1 sample returns the block to idle.
- R6: A flushee_start_i pulse taken while idle enters the flushee role directly, with ack_o=1 and data_oe_o=0.
- R7: If any wait for a clock level lasts POLL_LIMIT cycles, the block sets timeout_o, drives ack_o=1 and data_oe_o=0, and goes idle. timeout_o stays set until the next accepted start strobe clears it.
- R8: Start strobes are ignored while busy_o is 1. If both strobes arrive together while idle, flush_start_i wins.
- R9: lclk_i and ldata_i reach the decision logic only through a SYNC_STAGES-flop synchronizer, so every output follows a link-line change after the synchronizer latency.
- R10: done_o pulses for exactly one cycle when a flushee data sample of 1 ends the flush. It is never asserted together with timeout_o or busy_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lclk_i | input | 1 | Raw clock line driven by the guest |
| ldata_i | input | 1 | Raw shared data line level |
| flush_start_i | input | 1 | Start a flush as flusher (single-cycle strobe) |
| flushee_start_i | input | 1 | Start in the flush-receiving role (single-cycle strobe) |
| ack_o | output | 1 | Acknowledge line level driven to the guest |
| data_oe_o | output | 1 | Data line driver enable |
| data_o | output | 1 | Data line value when the driver is enabled |
| busy_o | output | 1 | A flush sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a flush ends successfully |
| timeout_o | output | 1 | Sticky flag: a clock wait ran out |

## Verification
The assertions assume that the start strobes are the only way out of idle, and that the guest clock holds each level for longer than the synchronizer latency plus one response cycle. Under that assumption every acknowledge edge lands inside a busy sequence. The stimulus uses a free-running guest clock with half-periods of at least four cycles, and a stalled clock held at a fixed level for the timeout cases. The guest releases data according to a programmed count of low samples. The bench keeps strobes one cycle wide. It only overlaps them with busy periods, or with each other, in the cases written to check that they are ignored or that flush wins.

// File: rtl/tw_flush_pkg.sv
package tw_flush_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_FL_LO  = 3'd1,
      ST_FL_HI  = 3'd2,
      ST_FL_REL = 3'd3,
      ST_EE_HI  = 3'd4,
      ST_EE_LO  = 3'd5
   } tw_state_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] sr_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sr_q <= RST_VAL;
            else         sr_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
            else         sr_q <= {sr_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/tw_wait_timer.sv
module tw_wait_timer #(
   parameter int LIMIT = 10000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic run_i,
   output logic expire_o
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (run_i)  cnt_q <= cnt_q + CW'(1);
   end

   assign expire_o = (cnt_q == LAST);

endmodule

// File: rtl/tw_flush_fsm.sv
module tw_flush_fsm
   import tw_flush_pkg::*;
#(
   parameter int FLUSH_CYCLES = 36
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sclk_i,
   input  logic sdata_i,
   input  logic flush_go_i,
   input  logic flushee_go_i,
   input  logic expire_i,
   output logic ack_o,
   output logic oe_o,
   output logic dat_o,
   output logic busy_o,
   output logic done_o,
   output logic tmo_o,
   output logic tmr_clr_o,
   output logic tmr_run_o
);

   localparam int HW = $clog2(FLUSH_CYCLES + 1);
   localparam logic [HW-1:0] HS_LAST = HW'(FLUSH_CYCLES - 1);

   tw_state_e st_q, st_d;
   logic [HW-1:0] hs_q, hs_d;
   logic ack_q, ack_d, oe_q, oe_d, dat_q, dat_d, to_q, to_d, done_q, done_d;

   always_comb begin
      st_d   = st_q;
      hs_d   = hs_q;
      ack_d  = ack_q;
      oe_d   = oe_q;
      dat_d  = dat_q;
      to_d   = to_q;
      done_d = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (flush_go_i) begin
               st_d  = ST_FL_LO;
               oe_d  = 1'b1;
               dat_d = 1'b0;
               to_d  = 1'b0;
               hs_d  = '0;
            end else if (flushee_go_i) begin
               st_d  = ST_EE_HI;
               ack_d = 1'b1;
               oe_d  = 1'b0;
               to_d  = 1'b0;
            end
         end
         ST_FL_LO: begin
            if (!sclk_i) begin
               ack_d = 1'b0;
               st_d  = ST_FL_HI;
            end
         end
         ST_FL_HI: begin
            if (sclk_i) begin
               ack_d = 1'b1;
               if (hs_q == HS_LAST) begin
                  st_d = ST_FL_REL;
               end else begin
                  hs_d = hs_q + HW'(1);
                  st_d = ST_FL_LO;
               end
            end
         end
         ST_FL_REL: begin
            if (!sclk_i) begin
               dat_d = 1'b1;
               st_d  = ST_EE_HI;
            end
         end
         ST_EE_HI: begin
            oe_d = 1'b0;
            if (sclk_i) begin
               ack_d = 1'b1;
               if (sdata_i) begin
                  done_d = 1'b1;
                  st_d   = ST_IDLE;
               end else begin
                  st_d = ST_EE_LO;
               end
            end
         end
         ST_EE_LO: begin
            oe_d = 1'b0;
            if (!sclk_i) begin
               ack_d = 1'b0;
               st_d  = ST_EE_HI;
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (st_q != ST_IDLE && st_d == st_q && expire_i) begin
         st_d  = ST_IDLE;
         to_d  = 1'b1;
         ack_d = 1'b1;
         oe_d  = 1'b0;
         dat_d = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         hs_q   <= '0;
         ack_q  <= 1'b1;
         oe_q   <= 1'b0;
         dat_q  <= 1'b0;
         to_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         hs_q   <= hs_d;
         ack_q  <= ack_d;
         oe_q   <= oe_d;
         dat_q  <= dat_d;
         to_q   <= to_d;
         done_q <= done_d;
      end
   end

   assign ack_o     = ack_q;
   assign oe_o      = oe_q;
   assign dat_o     = dat_q;
   assign tmo_o     = to_q;
   assign done_o    = done_q;
   assign busy_o    = (st_q != ST_IDLE);
   assign tmr_clr_o = (st_d != st_q);
   assign tmr_run_o = (st_q != ST_IDLE);

endmodule

// File: rtl/tw_flush_ctrl.sv
module tw_flush_ctrl #(
   parameter int FLUSH_CYCLES = 36,
   parameter int POLL_LIMIT   = 10000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lclk_i,
   input  logic ldata_i,
   input  logic flush_start_i,
   input  logic flushee_start_i,
   output logic ack_o,
   output logic data_oe_o,
   output logic data_o,
   output logic busy_o,
   output logic done_o,
   output logic timeout_o
);

   generate
      if (FLUSH_CYCLES < 1) begin : g_bad_cycles
         $error("tw_flush_ctrl: FLUSH_CYCLES must be at least 1");
      end
      if (POLL_LIMIT < 2) begin : g_bad_limit
         $error("tw_flush_ctrl: POLL_LIMIT must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tw_flush_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic sclk, sdata, expire, tmr_clr, tmr_run;

   tw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (lclk_i), .q_o (sclk)
   );

   tw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_data (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (ldata_i), .q_o (sdata)
   );

   tw_wait_timer #(.LIMIT(POLL_LIMIT)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (tmr_clr),
      .run_i    (tmr_run),
      .expire_o (expire)
   );

   tw_flush_fsm #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sclk_i       (sclk),
      .sdata_i      (sdata),
      .flush_go_i   (flush_start_i),
      .flushee_go_i (flushee_start_i),
      .expire_i     (expire),
      .ack_o        (ack_o),
      .oe_o         (data_oe_o),
      .dat_o        (data_o),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .tmo_o        (timeout_o),
      .tmr_clr_o    (tmr_clr),
      .tmr_run_o    (tmr_run)
   );

endmodule

// File: rtl/tw_flush_chk.sv
module tw_flush_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic flush_start_i,
   input logic ack_o,
   input logic data_oe_o,
   input logic data_o,
   input logic busy_o,
   input logic done_o,
   input logic timeout_o
);

   // R1, R7: whenever idle the link is left at its idle levels
   a_r1_idle_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (ack_o && !data_oe_o));

   // R2, R8: the data driver only switches on from idle on a flush strobe
   a_r2_drive_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(data_oe_o) |-> ($past(flush_start_i) && !$past(busy_o)));

   // R3, R5: acknowledge falls only inside a running sequence
   a_r3_ack_fall_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ack_o) |-> busy_o);

   // R4: data is raised while still driven, inside the sequence
   a_r4_raise_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(data_o) |-> (data_oe_o && busy_o));

   // R7: the timeout flag appears together with the return to idle
   a_r7_timeout_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(timeout_o) |-> !busy_o);

   // R10: done is a single-cycle pulse
   a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R10: done never overlaps timeout or busy
   a_r10_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!timeout_o && !busy_o));

endmodule

bind tw_flush_ctrl tw_flush_chk u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .flush_start_i (flush_start_i),
   .ack_o         (ack_o),
   .data_oe_o     (data_oe_o),
   .data_o        (data_o),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .timeout_o     (timeout_o)
);

// File: tb/tw_flush_ctrl_tb.sv
module tw_flush_ctrl_tb;

   localparam int FC   = 36;
   localparam int POLL = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lclk = 1'b1;
   logic ldata = 1'b1;
   logic fs = 1'b0;
   logic es = 1'b0;
   logic ack_o, data_oe_o, data_o, busy_o, done_o, timeout_o;

   always #10 clk = ~clk;

   tw_flush_ctrl #(.FLUSH_CYCLES(FC), .POLL_LIMIT(POLL), .SYNC_STAGES(2)) u_dut (
      .clk_i (clk), .rst_ni (rst_n), .lclk_i (lclk), .ldata_i (ldata),
      .flush_start_i (fs), .flushee_start_i (es),
      .ack_o (ack_o), .data_oe_o (data_oe_o), .data_o (data_o),
      .busy_o (busy_o), .done_o (done_o), .timeout_o (timeout_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_mode = 0;          // 0 idle,1 flush wait low,2 flush wait high,3 release wait,4 flushee wait high,5 flushee wait low
   int m_wait = 0;
   int m_hs = 0;
   bit m_ack = 1, m_oe = 0, m_dat = 0, m_to = 0, m_done = 0;
   bit m_c1 = 1, m_c2 = 1, m_d1 = 1, m_d2 = 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_wait = 0; m_hs = 0;
         m_ack = 1; m_oe = 0; m_dat = 0; m_to = 0; m_done = 0;
         m_c1 = 1; m_c2 = 1; m_d1 = 1; m_d2 = 1;
      end else begin
         bit c, d;
         int nxt;
         c = m_c2; d = m_d2; nxt = m_mode; m_done = 0;
         case (m_mode)
            0: if (fs) begin nxt = 1; m_oe = 1; m_dat = 0; m_to = 0; m_hs = 0; end
               else if (es) begin nxt = 4; m_ack = 1; m_oe = 0; m_to = 0; end
            1: if (!c) begin m_ack = 0; nxt = 2; end
            2: if (c) begin
                  m_ack = 1;
                  if (m_hs == FC - 1) nxt = 3;
                  else begin m_hs++; nxt = 1; end
               end
            3: if (!c) begin m_dat = 1; nxt = 4; end
            4: begin
                  m_oe = 0;
                  if (c) begin
                     m_ack = 1;
                     if (d) begin m_done = 1; nxt = 0; end
                     else nxt = 5;
                  end
               end
            5: begin m_oe = 0; if (!c) begin m_ack = 0; nxt = 4; end end
            default: nxt = 0;
         endcase
         if (m_mode != 0) begin
            if (nxt != m_mode) m_wait = 0;
            else if (m_wait == POLL - 1) begin
               nxt = 0; m_to = 1; m_ack = 1; m_oe = 0; m_dat = 0; m_wait = 0;
            end else m_wait++;
         end
         m_mode = nxt;
         m_c2 = m_c1; m_c1 = lclk;
         m_d2 = m_d1; m_d1 = ldata;
      end
   end

   // ---------------- guest, bus, monitor, compare ----------------
   bit g_run = 0;
   bit g_idle_lvl = 1;
   int g_half = 4;
   int tb_low = 0;
   bit tb_arm = 0;
   int load_id = 0;

   int seen_id = 0;
   int g_ph = 0;
   int g_low = 0;
   bit g_arm = 0;
   bit gdata = 1;
   bit prev_ack = 1;
   int fl_hs = 0, ee_falls = 0, high_drv = 0, dones = 0, cyc = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         // R9: every output follows the synchronized link lines cycle by cycle
         check(ack_o == m_ack, "R3 ack", ack_o, m_ack);
         check(data_oe_o == m_oe, "R2 data_oe", data_oe_o, m_oe);
         check(data_o == m_dat, "R4 data", data_o, m_dat);
         check(busy_o == (m_mode != 0), "R8 busy", busy_o, m_mode != 0);
         check(done_o == m_done, "R10 done", done_o, m_done);
         check(timeout_o == m_to, "R7 timeout", timeout_o, m_to);
      end
      if (prev_ack && !ack_o) begin
         if (data_oe_o && !data_o) fl_hs++;
         else if (!data_oe_o && busy_o) ee_falls++;
      end
      prev_ack = ack_o;
      if (data_oe_o && data_o) begin high_drv++; g_arm = 1; end
      if (done_o) dones++;
      if (load_id != seen_id) begin
         seen_id = load_id; g_low = tb_low; gdata = 0; g_arm = tb_arm;
      end
      if (g_run) begin
         g_ph++;
         if (g_ph >= g_half) begin
            g_ph = 0;
            lclk = ~lclk;
            if (!lclk && g_arm) begin
               if (g_low > 0) begin g_low--; gdata = 0; end
               else gdata = 1;
            end
         end
      end else begin
         lclk = g_idle_lvl; g_ph = 0;
      end
      ldata = gdata & ~(data_oe_o & ~data_o);
      if (cyc >= 150000 && !finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic pulse(input bit f, input bit e);
      @(negedge clk); fs = f; es = e;
      @(negedge clk); fs = 0; es = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000; i++) begin
         if (!busy_o) break;
         @(negedge clk);
      end
   endtask

   task automatic load_guest(input int low, input bit arm);
      tb_low = low; tb_arm = arm; load_id++;
      @(negedge clk);
   endtask

   initial begin
      int hs0, ee0, hd0, dn0, cnt;
      repeat (4) @(negedge clk);
      // R1: reset values
      check(ack_o == 1, "R1 ack in reset", ack_o, 1);
      check(data_oe_o == 0, "R1 oe in reset", data_oe_o, 0);
      check(busy_o == 0, "R1 busy in reset", busy_o, 0);
      check(done_o == 0 && timeout_o == 0, "R1 flags in reset", done_o | timeout_o, 0);
      rst_n = 1;
      @(negedge clk);
      check(ack_o == 1 && busy_o == 0, "R1 after reset", ack_o, 1);

      // Full flush as flusher then flushee, guest half-period 4
      g_half = 4; g_run = 1;
      load_guest(2, 0);
      hs0 = fl_hs; ee0 = ee_falls; hd0 = high_drv; dn0 = dones;
      pulse(1, 0);
      check(busy_o == 1 && data_oe_o == 1 && data_o == 0, "R2 flusher start", data_oe_o, 1);
      repeat (30) @(negedge clk);
      pulse(0, 1);   // ignored while busy
      check(data_oe_o == 1 && busy_o == 1, "R8 flushee strobe ignored", data_oe_o, 1);
      wait_idle();
      @(negedge clk);
      check(fl_hs - hs0 == FC, "R3 flusher handshakes", fl_hs - hs0, FC);
      check(high_drv - hd0 == 1, "R4 one-cycle high drive", high_drv - hd0, 1);
      check(ee_falls - ee0 == 3, "R5 flushee extra handshakes", ee_falls - ee0, 3);
      check(dones - dn0 == 1, "R10 single done pulse", dones - dn0, 1);
      check(timeout_o == 0 && ack_o == 1, "R5 ends at idle", timeout_o, 0);

      // Flushee entered on its own, guest half-period 5
      g_half = 5;
      load_guest(1, 1);
      dn0 = dones;
      pulse(0, 1);
      check(busy_o == 1 && data_oe_o == 0 && ack_o == 1, "R6 flushee start", busy_o, 1);
      wait_idle();
      @(negedge clk);
      check(dones - dn0 == 1, "R6 flushee completes", dones - dn0, 1);

      // Both strobes together: flush wins
      g_half = 4;
      load_guest(0, 0);
      pulse(1, 1);
      check(data_oe_o == 1 && data_o == 0, "R8 flush has priority", data_oe_o, 1);
      wait_idle();
      @(negedge clk);
      check(timeout_o == 0, "R8 priority run completes", timeout_o, 0);

      // Timeout with a stalled guest clock held high
      g_run = 0; g_idle_lvl = 1;
      load_guest(0, 0);
      repeat (4) @(negedge clk);
      pulse(1, 0);
      cnt = 0;
      while (busy_o && cnt < 1000) begin cnt++; @(negedge clk); end
      check(cnt == POLL, "R7 wait length", cnt, POLL);
      check(timeout_o == 1, "R7 timeout set", timeout_o, 1);
      check(ack_o == 1 && data_oe_o == 0, "R7 link released", data_oe_o, 0);
      repeat (5) @(negedge clk);
      check(timeout_o == 1, "R7 timeout sticky", timeout_o, 1);

      // Flushee with data low and clock stalled high: clear then time out again
      pulse(0, 1);
      check(timeout_o == 0, "R7 cleared by start", timeout_o, 0);
      wait_idle();
      @(negedge clk);
      check(timeout_o == 1 && busy_o == 0, "R7 second timeout", timeout_o, 1);

      // Recovery: guest runs again, flushee completes
      g_run = 1; g_half = 6;
      load_guest(2, 1);
      dn0 = dones;
      pulse(0, 1);
      wait_idle();
      @(negedge clk);
      check(dones - dn0 == 1, "R5 recovery done", dones - dn0, 1);
      check(timeout_o == 0, "R7 recovery no timeout", timeout_o, 0);

      repeat (10) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule